// File: doc/BRIEF.md
# Accumulator Snapshot Readback Interface

This block sits on the host side of a loop-tracking receiver. It lets a host read the receiver's tracking state over a narrow 8-bit bus. The carrier, symbol-tracking and gain loops each run an accumulator that never stops. A single write command copies all three into private holding registers in the same cycle, so the host can read a consistent set of values one byte at a time while the live values keep moving.

The lock detector's three accumulators are held in a similar way. Their holding registers are loaded at the moment the detector enters its stopped state, and they stay unchanged until the next time it stops.

A read takes two address levels. A 3-bit read-select register, loaded by its own strobe, picks one holding register or one lock-detector group. A 3-bit byte address then picks the byte that goes onto the bus. One byte address is reserved for an 8-bit status word, and that word is refreshed every clock. The same command decoder can also ask the lock detector to stop.

Top module: `acc_readback`

## Requirements
- R1: After synchronous reset, `rdata` is 0 and `rdata_vld` is 0. Every holding register is zero, so any read before a snapshot returns 0x00.
- R2: When `wr_stb` is high with `wr_addr` = 29 at a clock edge, three values are copied in that same edge. The carrier holding register takes the top 32 bits of `car_lag_acc`. The symbol holding register takes the top 32 bits of `sym_lag_acc`. The gain holding register takes the top 8 bits of `agc_acc`.
- R3: The loop holding registers keep their contents when the live accumulators change. They also keep them on any command value other than 29.
- R4: The read-select register is loaded from `rsel_din` when `rsel_we` is high. Its codes are: 0 for carrier, 1 for symbol, 2 for gain, 3 for lock group A and 4 for lock group B. Codes 5, 6 and 7 return 0x00 at every byte address except 4.
- R5: For the carrier and symbol registers, byte address 3 returns bits 31:24, address 2 returns bits 23:16, address 1 returns bits 15:8 and address 0 returns bits 7:0. For the gain register only byte address 0 returns data. Every other byte address except 4 returns 0x00.
- R6: With select 3, byte address 3 returns the phase-error MSByte and 2 returns its LSByte. Byte address 1 returns the false-lock MSByte and 0 returns its LSByte. Both are 16-bit registers.
- R7: With select 4, byte address 1 returns the gain-error MSByte and 0 returns its LSByte. Byte addresses 2, 3, 5, 6 and 7 return 0x00.
- R8: Byte address 4 returns the status register, whatever the read select is. The status register is reloaded every clock with {`ld_stopped`, `ld_stopped`, `status_in[5:0]`}.
- R9: When `wr_stb` is high with `wr_addr` = 24 and `sm_mode` = 1, `ld_stop_req` is high for exactly the next cycle. With `sm_mode` = 0 the same write gives no pulse.
- R10: The lock holding registers load the top 16 bits of `ld_phase_acc`, `ld_false_acc` and `ld_gain_acc` only at an edge where `ld_stopped` rises. They stay frozen while the detector stays stopped, after it restarts, and until the next rising edge of `ld_stopped`.
- R11: A read with `rd_stb` high at an edge puts its byte on `rdata` with `rdata_vld` = 1 for the next cycle. When no read is in progress, `rdata` is 0x00 and `rdata_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| car_lag_acc | input | LAG_ACC_W | Live carrier-loop lag accumulator |
| sym_lag_acc | input | LAG_ACC_W | Live symbol-loop lag accumulator |
| agc_acc | input | AGC_ACC_W | Live gain-loop accumulator |
| ld_phase_acc | input | LD_ACC_W | Live lock-detector phase-error accumulator |
| ld_false_acc | input | LD_ACC_W | Live lock-detector false-lock accumulator |
| ld_gain_acc | input | LD_ACC_W | Live lock-detector gain-error accumulator |
| ld_stopped | input | 1 | Lock detector is halted and its accumulators are steady |
| sm_mode | input | 1 | 1 = lock detector runs under state-machine control |
| status_in | input | 6 | Loop status flags for status bits 5:0 |
| wr_stb | input | 1 | Command write strobe |
| wr_addr | input | 8 | Command value |
| rsel_we | input | 1 | Load strobe for the read-select register |
| rsel_din | input | 3 | New read-select value |
| rd_byte | input | 3 | Byte address |
| rd_stb | input | 1 | Read strobe |
| rdata | output | 8 | Read data byte |
| rdata_vld | output | 1 | Read data valid |
| ld_stop_req | output | 1 | One-cycle request to halt the lock detector |

## Verification
The bench changes the live accumulators right after each snapshot and again while a multi-byte read is under way. A design that tracked the live values instead of holding them would return mixed bytes from different moments.

It checks the reversed byte order of group A, the single valid byte of the gain register, and the unused byte addresses and select codes. A mux that indexed uniformly or let stale bits through would fail these.

It restarts the lock detector while the live values move, to catch a design that loads on level rather than on the rising edge. It also issues the stop command in both control modes, and reads status under a non-status select to show that byte address 4 takes priority.

// File: rtl/acc_rb_pkg.sv
package acc_rb_pkg;

    localparam int          CMD_W        = 8;
    localparam logic [7:0]  CMD_SNAPSHOT = 8'd29;
    localparam logic [7:0]  CMD_LD_HALT  = 8'd24;
    localparam logic [2:0]  BYTE_STATUS  = 3'd4;

    localparam int          WIDE_HOLD_W  = 32;
    localparam int          AGC_HOLD_W   = 8;
    localparam int          LD_HOLD_W    = 16;
    localparam int          N_LAG        = 2;

    typedef enum logic [2:0] {
        SEL_CAR = 3'd0,
        SEL_SYM = 3'd1,
        SEL_AGC = 3'd2,
        SEL_LDA = 3'd3,
        SEL_LDB = 3'd4
    } rd_sel_e;

    typedef struct packed {
        logic snap;
        logic halt;
    } cmd_t;

    typedef struct packed {
        logic [LD_HOLD_W-1:0] phase;
        logic [LD_HOLD_W-1:0] flock;
        logic [LD_HOLD_W-1:0] gerr;
    } ld_hold_t;

    function automatic logic [7:0] pick_byte32(input logic [31:0] w, input logic [2:0] b);
        logic [7:0] r;
        case (b)
            3'd0:    r = w[7:0];
            3'd1:    r = w[15:8];
            3'd2:    r = w[23:16];
            3'd3:    r = w[31:24];
            default: r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/acc_rb_cmd.sv
module acc_rb_cmd
    import acc_rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [CMD_W-1:0] wr_addr,
    input  logic             sm_mode,
    output cmd_t             cmd,
    output logic             ld_stop_req
);

    always_comb begin
        cmd.snap = wr_stb && (wr_addr == CMD_SNAPSHOT);
        cmd.halt = wr_stb && (wr_addr == CMD_LD_HALT) && sm_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) ld_stop_req <= 1'b0;
        else     ld_stop_req <= cmd.halt;
    end

endmodule

// File: rtl/acc_rb_hold.sv
module acc_rb_hold
    import acc_rb_pkg::*;
#(
    parameter int LAG_ACC_W = 32,
    parameter int AGC_ACC_W = 8,
    parameter int LD_ACC_W  = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 snap,
    input  logic [N_LAG-1:0][LAG_ACC_W-1:0]      lag_live,
    input  logic [AGC_ACC_W-1:0]                 agc_live,
    input  logic [LD_ACC_W-1:0]                  ld_phase_live,
    input  logic [LD_ACC_W-1:0]                  ld_false_live,
    input  logic [LD_ACC_W-1:0]                  ld_gain_live,
    input  logic                                 ld_stopped,
    output logic [N_LAG-1:0][WIDE_HOLD_W-1:0]    lag_hold,
    output logic [AGC_HOLD_W-1:0]                agc_hold,
    output ld_hold_t                             ld_hold
);

    logic ld_stopped_d;
    logic ld_load;

    for (genvar g = 0; g < N_LAG; g++) begin : g_lag
        always_ff @(posedge clk) begin
            if (rst)       lag_hold[g] <= '0;
            else if (snap) lag_hold[g] <= lag_live[g][LAG_ACC_W-1 -: WIDE_HOLD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       agc_hold <= '0;
        else if (snap) agc_hold <= agc_live[AGC_ACC_W-1 -: AGC_HOLD_W];
    end

    assign ld_load = ld_stopped && !ld_stopped_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_stopped_d <= 1'b0;
            ld_hold      <= '0;
        end else begin
            ld_stopped_d <= ld_stopped;
            if (ld_load) begin
                ld_hold.phase <= ld_phase_live[LD_ACC_W-1 -: LD_HOLD_W];
                ld_hold.flock <= ld_false_live[LD_ACC_W-1 -: LD_HOLD_W];
                ld_hold.gerr  <= ld_gain_live[LD_ACC_W-1 -: LD_HOLD_W];
            end
        end
    end

endmodule

// File: rtl/acc_rb_mux.sv
module acc_rb_mux
    import acc_rb_pkg::*;
(
    input  logic [2:0]                        rsel,
    input  logic [2:0]                        rbyte,
    input  logic [N_LAG-1:0][WIDE_HOLD_W-1:0] lag_hold,
    input  logic [AGC_HOLD_W-1:0]             agc_hold,
    input  ld_hold_t                          ld_hold,
    input  logic [7:0]                        status,
    output logic [7:0]                        byte_out
);

    always_comb begin
        byte_out = 8'h00;
        if (rbyte == BYTE_STATUS) begin
            byte_out = status;
        end else begin
            case (rd_sel_e'(rsel))
                SEL_CAR: byte_out = pick_byte32(lag_hold[0], rbyte);
                SEL_SYM: byte_out = pick_byte32(lag_hold[1], rbyte);
                SEL_AGC: byte_out = (rbyte == 3'd0) ? agc_hold : 8'h00;
                SEL_LDA: byte_out = pick_byte32({ld_hold.phase, ld_hold.flock}, rbyte);
                SEL_LDB: byte_out = pick_byte32({16'h0000, ld_hold.gerr}, rbyte);
                default: byte_out = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/acc_readback.sv
module acc_readback
    import acc_rb_pkg::*;
#(
    parameter int LAG_ACC_W = 32,
    parameter int AGC_ACC_W = 8,
    parameter int LD_ACC_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LAG_ACC_W-1:0] car_lag_acc,
    input  logic [LAG_ACC_W-1:0] sym_lag_acc,
    input  logic [AGC_ACC_W-1:0] agc_acc,
    input  logic [LD_ACC_W-1:0]  ld_phase_acc,
    input  logic [LD_ACC_W-1:0]  ld_false_acc,
    input  logic [LD_ACC_W-1:0]  ld_gain_acc,
    input  logic                 ld_stopped,
    input  logic                 sm_mode,
    input  logic [5:0]           status_in,
    input  logic                 wr_stb,
    input  logic [7:0]           wr_addr,
    input  logic                 rsel_we,
    input  logic [2:0]           rsel_din,
    input  logic [2:0]           rd_byte,
    input  logic                 rd_stb,
    output logic [7:0]           rdata,
    output logic                 rdata_vld,
    output logic                 ld_stop_req
);

    cmd_t                              cmd;
    logic [2:0]                        rsel_q;
    logic [7:0]                        status_q;
    logic [N_LAG-1:0][WIDE_HOLD_W-1:0] lag_hold;
    logic [AGC_HOLD_W-1:0]             agc_hold;
    ld_hold_t                          ld_hold;
    logic [7:0]                        mux_byte;

    acc_rb_cmd u_cmd (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .sm_mode     (sm_mode),
        .cmd         (cmd),
        .ld_stop_req (ld_stop_req)
    );

    acc_rb_hold #(
        .LAG_ACC_W (LAG_ACC_W),
        .AGC_ACC_W (AGC_ACC_W),
        .LD_ACC_W  (LD_ACC_W)
    ) u_hold (
        .clk           (clk),
        .rst           (rst),
        .snap          (cmd.snap),
        .lag_live      ({sym_lag_acc, car_lag_acc}),
        .agc_live      (agc_acc),
        .ld_phase_live (ld_phase_acc),
        .ld_false_live (ld_false_acc),
        .ld_gain_live  (ld_gain_acc),
        .ld_stopped    (ld_stopped),
        .lag_hold      (lag_hold),
        .agc_hold      (agc_hold),
        .ld_hold       (ld_hold)
    );

    acc_rb_mux u_mux (
        .rsel     (rsel_q),
        .rbyte    (rd_byte),
        .lag_hold (lag_hold),
        .agc_hold (agc_hold),
        .ld_hold  (ld_hold),
        .status   (status_q),
        .byte_out (mux_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsel_q    <= 3'd0;
            status_q  <= 8'h00;
            rdata     <= 8'h00;
            rdata_vld <= 1'b0;
        end else begin
            if (rsel_we) rsel_q <= rsel_din;
            status_q  <= {ld_stopped, ld_stopped, status_in};
            rdata     <= rd_stb ? mux_byte : 8'h00;
            rdata_vld <= rd_stb;
        end
    end

endmodule

// File: rtl/acc_readback_chk.sv
module acc_readback_chk
    import acc_rb_pkg::*;
(
    input logic                                 clk,
    input logic                                 rst,
    input logic                                 wr_stb,
    input logic [7:0]                           wr_addr,
    input logic                                 sm_mode,
    input logic                                 ld_stopped,
    input logic                                 rd_stb,
    input logic [2:0]                           rd_byte,
    input logic [7:0]                           rdata,
    input logic                                 rdata_vld,
    input logic                                 ld_stop_req,
    input logic [7:0]                           status_q,
    input logic [N_LAG-1:0][WIDE_HOLD_W-1:0]    lag_hold,
    input logic [AGC_HOLD_W-1:0]                agc_hold,
    input ld_hold_t                             ld_hold
);

    AST_LAG_HELD: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && wr_addr == CMD_SNAPSHOT) |=> ($stable(lag_hold) && $stable(agc_hold))); // R3

    AST_LD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !ld_stopped |=> $stable(ld_hold)); // R10

    AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ld_stop_req |-> $past(wr_stb && wr_addr == CMD_LD_HALT && sm_mode)); // R9

    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ld_stop_req |=> !ld_stop_req); // R9

    AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rdata_vld); // R11

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rdata_vld |-> (rdata == 8'h00)); // R11

    AST_STATUS_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_byte == BYTE_STATUS) |=> (rdata == $past(status_q))); // R8

endmodule

bind acc_readback acc_readback_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .sm_mode     (sm_mode),
    .ld_stopped  (ld_stopped),
    .rd_stb      (rd_stb),
    .rd_byte     (rd_byte),
    .rdata       (rdata),
    .rdata_vld   (rdata_vld),
    .ld_stop_req (ld_stop_req),
    .status_q    (status_q),
    .lag_hold    (lag_hold),
    .agc_hold    (agc_hold),
    .ld_hold     (ld_hold)
);

// File: tb/sim_acc_readback.sv
module sim_acc_readback;

    localparam int LAG_W = 32;
    localparam int AGC_W = 8;
    localparam int LDW   = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic [LAG_W-1:0] car_lag_acc, sym_lag_acc;
    logic [AGC_W-1:0] agc_acc;
    logic [LDW-1:0]   ld_phase_acc, ld_false_acc, ld_gain_acc;
    logic             ld_stopped, sm_mode;
    logic [5:0]       status_in;
    logic             wr_stb;
    logic [7:0]       wr_addr;
    logic             rsel_we;
    logic [2:0]       rsel_din;
    logic [2:0]       rd_byte;
    logic             rd_stb;
    logic [7:0]       rdata;
    logic             rdata_vld;
    logic             ld_stop_req;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #4 clk = ~clk;

    acc_readback #(.LAG_ACC_W(LAG_W), .AGC_ACC_W(AGC_W), .LD_ACC_W(LDW)) u0 (
        .clk(clk), .rst(rst),
        .car_lag_acc(car_lag_acc), .sym_lag_acc(sym_lag_acc), .agc_acc(agc_acc),
        .ld_phase_acc(ld_phase_acc), .ld_false_acc(ld_false_acc), .ld_gain_acc(ld_gain_acc),
        .ld_stopped(ld_stopped), .sm_mode(sm_mode), .status_in(status_in),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .rsel_we(rsel_we), .rsel_din(rsel_din),
        .rd_byte(rd_byte), .rd_stb(rd_stb),
        .rdata(rdata), .rdata_vld(rdata_vld), .ld_stop_req(ld_stop_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected bytes as the design presents them
    always @(negedge clk) begin
        if (!rst && rdata_vld) begin
            if (q_exp.size() == 0) begin
                check("R11 unexpected valid", 32'(rdata), 32'hFFFF_FFFF);
            end else begin
                check(q_tag.pop_front(), 32'(rdata), 32'(q_exp.pop_front()));
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic command(input logic [7:0] v);
        wr_stb = 1'b1; wr_addr = v;
        tick();
        wr_stb = 1'b0; wr_addr = 8'h00;
    endtask

    task automatic select(input logic [2:0] s);
        rsel_we = 1'b1; rsel_din = s;
        tick();
        rsel_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] b, input logic [7:0] exp, input string tag);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        rd_stb = 1'b1; rd_byte = b;
        tick();
        rd_stb = 1'b0; rd_byte = 3'd0;
    endtask

    task automatic drain();
        while (q_exp.size() != 0) tick();
        tick();
    endtask

    initial begin
        #800000;
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] car0, sym0;
        logic [7:0]  agc0;
        rst = 1'b1;
        car_lag_acc = '0; sym_lag_acc = '0; agc_acc = '0;
        ld_phase_acc = '0; ld_false_acc = '0; ld_gain_acc = '0;
        ld_stopped = 1'b0; sm_mode = 1'b0; status_in = '0;
        wr_stb = 1'b0; wr_addr = '0; rsel_we = 1'b0; rsel_din = '0;
        rd_byte = '0; rd_stb = 1'b0;
        repeat (3) tick();
        check("R1 rdata after reset", 32'(rdata), 32'h0);
        check("R1 rdata_vld after reset", 32'(rdata_vld), 32'h0);
        check("R9 ld_stop_req after reset", 32'(ld_stop_req), 32'h0);
        rst = 1'b0;
        tick();
        rd(3'd3, 8'h00, "R1 carrier before snapshot");
        select(3'd3);
        rd(3'd1, 8'h00, "R1 group A before load");
        select(3'd0);
        drain();
        check("R11 idle bus", 32'(rdata), 32'h0);

        // snapshot, then disturb live values during reads
        car0 = 32'hA1B2_C3D4; sym0 = 32'h1357_9BDF; agc0 = 8'h5E;
        car_lag_acc = car0; sym_lag_acc = sym0; agc_acc = agc0;
        command(8'd29);
        car_lag_acc = 32'hFFFF_0000; sym_lag_acc = 32'h0000_FFFF; agc_acc = 8'hC3;
        rd(3'd3, car0[31:24], "R5 carrier byte3");
        car_lag_acc = 32'h7777_7777;
        rd(3'd2, car0[23:16], "R5 carrier byte2");
        rd(3'd1, car0[15:8],  "R5 carrier byte1");
        rd(3'd0, car0[7:0],   "R2 carrier byte0");
        rd(3'd5, 8'h00,       "R5 carrier unused byte5");
        rd(3'd7, 8'h00,       "R5 carrier unused byte7");
        select(3'd1);
        rd(3'd3, sym0[31:24], "R2 symbol byte3");
        rd(3'd0, sym0[7:0],   "R4 symbol byte0");
        select(3'd2);
        rd(3'd0, agc0,        "R2 gain byte0");
        rd(3'd1, 8'h00,       "R5 gain byte1 unused");
        rd(3'd3, 8'h00,       "R5 gain byte3 unused");

        // other command values do not snapshot
        command(8'd23);
        command(8'd24);
        rd(3'd0, agc0, "R3 gain after non-snapshot cmd");
        select(3'd0);
        rd(3'd2, car0[23:16], "R3 carrier after non-snapshot cmd");
        command(8'd29);
        rd(3'd3, 8'h77, "R2 carrier resnapshot");
        select(3'd5);
        rd(3'd3, 8'h00, "R4 select5 zero");
        select(3'd7);
        rd(3'd0, 8'h00, "R4 select7 zero");
        drain();

        // lock detector capture on rising stop
        ld_phase_acc = 16'hBEEF; ld_false_acc = 16'hCAFE; ld_gain_acc = 16'h1234;
        ld_stopped = 1'b1;
        tick();
        ld_phase_acc = 16'h0101; ld_false_acc = 16'h0202; ld_gain_acc = 16'h0303;
        select(3'd3);
        rd(3'd3, 8'hBE, "R6 phase MSByte");
        rd(3'd2, 8'hEF, "R6 phase LSByte");
        rd(3'd1, 8'hCA, "R6 false MSByte");
        rd(3'd0, 8'hFE, "R10 false LSByte held while stopped");
        select(3'd4);
        rd(3'd1, 8'h12, "R7 gain-error MSByte");
        rd(3'd0, 8'h34, "R7 gain-error LSByte");
        rd(3'd2, 8'h00, "R7 unused byte2");
        rd(3'd3, 8'h00, "R7 unused byte3");
        ld_stopped = 1'b0;
        tick();
        ld_gain_acc = 16'h9999;
        tick();
        rd(3'd0, 8'h34, "R10 frozen after restart");
        ld_stopped = 1'b1;
        tick();
        rd(3'd1, 8'h99, "R10 reload on next stop");
        drain();

        // status priority
        status_in = 6'h2A;
        tick();
        select(3'd0);
        rd(3'd4, 8'hEA, "R8 status under select0");
        select(3'd3);
        rd(3'd4, 8'hEA, "R8 status under select3");
        ld_stopped = 1'b0;
        tick();
        rd(3'd4, 8'h2A, "R8 status not stopped");
        drain();

        // halt command
        sm_mode = 1'b1;
        command(8'd24);
        check("R9 halt pulse in sm mode", 32'(ld_stop_req), 32'h1);
        tick();
        check("R9 halt pulse ends", 32'(ld_stop_req), 32'h0);
        sm_mode = 1'b0;
        command(8'd24);
        check("R9 no halt in host mode", 32'(ld_stop_req), 32'h0);
        tick();
        check("R11 no valid without strobe", 32'(rdata_vld), 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule